// File: doc/BRIEF.md
# Indexed Load/Store Execution Unit

This unit executes a group of memory instructions that form their address from two integer registers plus a small signed immediate. It sits in the execute stage of a 64-bit pipeline. It receives the instruction word, the register values already read from the integer and floating-point files, and a flag that says whether the floating-point coprocessor is usable. From these it decodes the access size and target, raises any exception, issues a single-beat request to a little-endian 64-bit data memory, and returns the loaded value, extended as the target requires, for writeback.

An instruction presented with `valid_i` high is registered at the next clock edge. The memory request or the exception is visible for the cycle that follows. The memory answers in that same cycle on `mem_rdata_i`, and the writeback appears one cycle later. Instructions whose major opcode belongs to another unit are ignored, as are all instructions when the extension is switched off.

Top module: `idx_ldst_unit`

## Requirements
- R1: Only major opcode 6'h36 (load) or 6'h3E (store) in instr_i[31:26] with ext_en_i high is acted on; any other instruction produces no request, no exception and no writeback.
- R2: The effective address is rs_val_i + rd_val_i + sign-extended instr_i[10:3]. It is driven on mem_addr_o with mem_req_o high in the cycle after valid_i is sampled.
- R3: instr_i[2:0] selects the access: 0, 1, 2 and 3 move 1, 2, 4 and 8 bytes for the integer register file, while 6 and 7 move 4 and 8 bytes for the floating-point file; codes 4 and 5 give exception code 1 (reserved instruction); at most one of gpr_we_o and fpr_we_o is ever high.
- R4: An integer load writes the target named by instr_i[20:16] one cycle after its request; loaded bytes, halfwords and words are sign-extended to 64 bits, and doublewords are taken whole.
- R5: A load with instr_i[20:16] equal to zero is a prefetch: no request, no writeback, and no alignment exception.
- R6: Codes 6 and 7 (loads and stores) with cp1_en_i low give exception code 2 (coprocessor unusable).
- R7: A store drives mem_be_o with one bit for each byte of the access, starting at lane mem_addr_o[2:0], and places the low bytes of the source register (the floating-point value for codes 6 and 7) repeated across all eight lanes of mem_wdata_o, byte k of the bus carrying source byte k modulo the size.
- R8: A 4-byte floating-point load replaces the low 32 bits of the target and keeps the upper 32 bits that fpr_val_i held at issue.
- R9: An access whose address is not a multiple of its size gives exception code 3 for a load or code 4 for a store.
- R10: Exactly one code is reported per instruction, with priority 1 over 2 over 3/4. An exception cycle carries no memory request, and no writeback follows it. Code 0 and exc_valid_o low mean no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| ext_en_i | input | 1 | Extension enabled |
| cp1_en_i | input | 1 | Floating-point coprocessor usable |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | First base register value |
| rd_val_i | input | 64 | Index register value |
| rt_val_i | input | 64 | Integer source value for stores |
| fpr_val_i | input | 64 | Floating-point register value of the rt field |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_be_o | output | 8 | Byte lane enables |
| mem_wdata_o | output | 64 | Write data, replicated across lanes |
| mem_rdata_i | input | 64 | Read data returned in the request cycle |
| gpr_we_o | output | 1 | Integer register write |
| fpr_we_o | output | 1 | Floating-point register write |
| wb_idx_o | output | 5 | Writeback register number |
| wb_data_o | output | 64 | Writeback value |
| exc_valid_o | output | 1 | Exception raised |
| exc_code_o | output | 3 | Exception code |

## Verification
Loads are tried at every size and at several byte lanes, using memory data whose bytes have the sign bit set in some lanes and clear in others. This shows whether the lane shift is correct and whether the extension is signed. Stores at each size and lane show whether the byte enables and the lane replication line up. A negative immediate shows whether the offset is sign-extended. Separate instructions combine a reserved code, a disabled coprocessor, a misaligned address and a zero target, one pairing at a time, which confirms the exception priority and confirms that a prefetch never faults.

// File: rtl/idx_ldst_pkg.sv
package idx_ldst_pkg;

    localparam logic [5:0] OP_LOAD  = 6'h36;
    localparam logic [5:0] OP_STORE = 6'h3E;

    typedef enum logic [2:0] {
        EXC_NONE     = 3'd0,
        EXC_RSVD     = 3'd1,
        EXC_COP      = 3'd2,
        EXC_ALIGN_LD = 3'd3,
        EXC_ALIGN_ST = 3'd4
    } exc_e;

    typedef struct packed {
        logic       hit;
        logic       is_load;
        logic       to_fpr;
        logic [1:0] size_log;
        logic       prefetch;
        exc_e       exc;
    } dec_t;

endpackage

// File: rtl/idx_ldst_decode.sv
module idx_ldst_decode
    import idx_ldst_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  logic              ext_en_i,
    input  logic              cp1_en_i,
    input  logic [5:0]        major_i,
    input  logic [4:0]        rt_i,
    input  logic [2:0]        minor_i,
    input  logic [LANE_W-1:0] lane_i,
    output dec_t              dec_o
);
    logic              legal;
    logic [LANE_W:0]   span;
    logic [LANE_W-1:0] mask;
    logic              misalign;

    always_comb begin
        dec_o          = '0;
        dec_o.hit      = ext_en_i && (major_i == OP_LOAD || major_i == OP_STORE);
        dec_o.is_load  = (major_i == OP_LOAD);
        legal          = 1'b1;
        unique case (minor_i)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                dec_o.size_log = minor_i[1:0];
                dec_o.to_fpr   = 1'b0;
            end
            3'd6: begin
                dec_o.size_log = 2'd2;
                dec_o.to_fpr   = 1'b1;
            end
            3'd7: begin
                dec_o.size_log = 2'd3;
                dec_o.to_fpr   = 1'b1;
            end
            default: begin
                dec_o.size_log = 2'd0;
                dec_o.to_fpr   = 1'b0;
                legal          = 1'b0;
            end
        endcase
        dec_o.prefetch = dec_o.is_load && (rt_i == 5'd0);
        span     = (LANE_W+1)'(1) << dec_o.size_log;
        mask     = LANE_W'(span - (LANE_W+1)'(1));
        misalign = (lane_i & mask) != '0;

        if (!dec_o.hit)                     dec_o.exc = EXC_NONE;
        else if (!legal)                    dec_o.exc = EXC_RSVD;
        else if (dec_o.to_fpr && !cp1_en_i) dec_o.exc = EXC_COP;
        else if (dec_o.prefetch)            dec_o.exc = EXC_NONE;
        else if (misalign)                  dec_o.exc = dec_o.is_load ? EXC_ALIGN_LD : EXC_ALIGN_ST;
        else                                dec_o.exc = EXC_NONE;
    end
endmodule

// File: rtl/idx_ldst_align.sv
module idx_ldst_align #(
    parameter int DATA_W = 64,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [1:0]        size_log_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [BYTES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic [LANE_W:0]   span;
    logic [LANE_W-1:0] mask;

    assign span = (LANE_W+1)'(1) << size_log_i;
    assign mask = LANE_W'(span - (LANE_W+1)'(1));

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        localparam logic [LANE_W-1:0] B = LANE_W'(b);
        logic [LANE_W-1:0] src_byte;
        assign src_byte            = B & mask;
        assign wdata_o[b*8 +: 8]   = src_i[src_byte*8 +: 8];
        assign be_o[b]             = ((B & ~mask) == (lane_i & ~mask));
    end
endmodule

// File: rtl/idx_ldst_extract.sv
module idx_ldst_extract #(
    parameter int DATA_W = 64,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES),
    localparam int HALF   = DATA_W / 2
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [1:0]        size_log_i,
    input  logic              to_fpr_i,
    input  logic [DATA_W-1:0] fpr_old_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] shifted;
    logic              unused_low;

    assign shifted    = rdata_i >> {lane_i, 3'b000};
    assign unused_low = ^fpr_old_i[HALF-1:0];

    always_comb begin
        if (to_fpr_i) begin
            data_o = (size_log_i == 2'd2) ? {fpr_old_i[DATA_W-1:HALF], shifted[HALF-1:0]}
                                          : shifted;
        end else begin
            unique case (size_log_i)
                2'd0:    data_o = {{(DATA_W-8){shifted[7]}},   shifted[7:0]};
                2'd1:    data_o = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
                2'd2:    data_o = {{(DATA_W-32){shifted[31]}}, shifted[31:0]};
                default: data_o = shifted;
            endcase
        end
    end
endmodule

// File: rtl/idx_ldst_unit.sv
module idx_ldst_unit
    import idx_ldst_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              ext_en_i,
    input  logic              cp1_en_i,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [DATA_W-1:0] rd_val_i,
    input  logic [DATA_W-1:0] rt_val_i,
    input  logic [DATA_W-1:0] fpr_val_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [BYTES-1:0]  mem_be_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              gpr_we_o,
    output logic              fpr_we_o,
    output logic [4:0]        wb_idx_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic              exc_valid_o,
    output logic [2:0]        exc_code_o
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [DATA_W-1:0] addr;
        logic [BYTES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        exc_e              exc;
        logic              ld_gpr;
        logic              ld_fpr;
        logic [4:0]        idx;
        logic [1:0]        size_log;
        logic [DATA_W-1:0] fpr_old;
        logic              gwe;
        logic              fwe;
        logic [4:0]        wb_idx;
        logic [DATA_W-1:0] wb_data;
    } st_t;

    st_t               st_d, st_q;
    dec_t              dec;
    logic [DATA_W-1:0] ea;
    logic [BYTES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] ld_data;
    logic              go;
    logic              unused_fields;

    assign unused_fields = ^{instr_i[25:21], instr_i[15:11]};
    assign ea = rs_val_i + rd_val_i + {{(DATA_W-8){instr_i[10]}}, instr_i[10:3]};

    idx_ldst_decode #(.LANE_W(LANE_W)) u_decode (
        .ext_en_i (ext_en_i),
        .cp1_en_i (cp1_en_i),
        .major_i  (instr_i[31:26]),
        .rt_i     (instr_i[20:16]),
        .minor_i  (instr_i[2:0]),
        .lane_i   (ea[LANE_W-1:0]),
        .dec_o    (dec)
    );

    idx_ldst_align #(.DATA_W(DATA_W)) u_align (
        .size_log_i (dec.size_log),
        .lane_i     (ea[LANE_W-1:0]),
        .src_i      (dec.to_fpr ? fpr_val_i : rt_val_i),
        .be_o       (be_c),
        .wdata_o    (wdata_c)
    );

    idx_ldst_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata_i    (mem_rdata_i),
        .lane_i     (st_q.addr[LANE_W-1:0]),
        .size_log_i (st_q.size_log),
        .to_fpr_i   (st_q.ld_fpr),
        .fpr_old_i  (st_q.fpr_old),
        .data_o     (ld_data)
    );

    always_comb begin
        go            = valid_i && dec.hit && (dec.exc == EXC_NONE) && !dec.prefetch;
        st_d          = st_q;
        st_d.req      = go;
        st_d.we       = go && !dec.is_load;
        st_d.addr     = ea;
        st_d.be       = go ? be_c : '0;
        st_d.wdata    = wdata_c;
        st_d.exc      = (valid_i && dec.hit) ? dec.exc : EXC_NONE;
        st_d.ld_gpr   = go && dec.is_load && !dec.to_fpr;
        st_d.ld_fpr   = go && dec.is_load && dec.to_fpr;
        st_d.idx      = instr_i[20:16];
        st_d.size_log = dec.size_log;
        st_d.fpr_old  = fpr_val_i;
        st_d.gwe      = st_q.ld_gpr;
        st_d.fwe      = st_q.ld_fpr;
        st_d.wb_idx   = st_q.idx;
        st_d.wb_data  = ld_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req_o   = st_q.req;
    assign mem_we_o    = st_q.we;
    assign mem_addr_o  = st_q.addr;
    assign mem_be_o    = st_q.be;
    assign mem_wdata_o = st_q.wdata;
    assign gpr_we_o    = st_q.gwe;
    assign fpr_we_o    = st_q.fwe;
    assign wb_idx_o    = st_q.wb_idx;
    assign wb_data_o   = st_q.wb_data;
    assign exc_valid_o = (st_q.exc != EXC_NONE);
    assign exc_code_o  = st_q.exc;

    AST_EXC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> !mem_req_o); // R10
    AST_EXC_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> !(gpr_we_o || fpr_we_o)); // R10
    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_we_o || fpr_we_o) |-> $past(mem_req_o && !mem_we_o)); // R4
    AST_WB_ONE_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_we_o, fpr_we_o})); // R3
    AST_BE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ($countones(mem_be_o) == (1 << st_q.size_log))); // R7
    AST_NO_WRITE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |=> !(gpr_we_o || fpr_we_o)); // R7
endmodule

// File: tb/idx_ldst_unit_tb_top.sv
module idx_ldst_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, ext_en_i = 1'b0, cp1_en_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] rs_val_i = '0, rd_val_i = '0, rt_val_i = '0, fpr_val_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i, wb_data_o;
    logic [7:0]  mem_be_o;
    logic        gpr_we_o, fpr_we_o, exc_valid_o;
    logic [4:0]  wb_idx_o;
    logic [2:0]  exc_code_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [63:0] pattern(logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h80F0_7F01_8E62_C3A4;
    endfunction

    assign mem_rdata_i = pattern({mem_addr_o[63:3], 3'b000});

    idx_ldst_unit dut_i (.*);

    typedef struct {
        string       tag;
        bit          req, we;
        logic [63:0] addr, wdata, wb;
        logic [7:0]  be;
        logic [2:0]  exc;
        bit          gwe, fwe;
        logic [4:0]  idx;
    } item_t;

    item_t q[$];

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic item_t predict(string tag, logic [5:0] op, logic [4:0] rt, logic [7:0] off,
                                      logic [2:0] minor, logic [63:0] rs, logic [63:0] rd,
                                      logic [63:0] rtv, logic [63:0] fpv, bit cp1, bit ext);
        item_t it;
        logic [63:0] ea, src, w;
        int n; bit fpr, legal, ld;
        it = '{tag: tag, default: '0};
        ea = rs + rd + {{56{off[7]}}, off};
        ld = (op == 6'h36);
        legal = 1; fpr = 0; n = 1;
        case (minor)
            0: n = 1; 1: n = 2; 2: n = 4; 3: n = 8;
            6: begin n = 4; fpr = 1; end
            7: begin n = 8; fpr = 1; end
            default: legal = 0;
        endcase
        if (!(ext && (op == 6'h36 || op == 6'h3E))) return it;
        if (!legal) begin it.exc = 1; return it; end
        if (fpr && !cp1) begin it.exc = 2; return it; end
        if (ld && rt == 0) return it;
        if ((ea % n) != 0) begin it.exc = ld ? 3 : 4; return it; end
        it.req = 1; it.we = !ld; it.addr = ea;
        it.be = 8'((16'(1) << n) - 1) << ea[2:0];
        src = fpr ? fpv : rtv;
        for (int b = 0; b < 8; b++) it.wdata[b*8 +: 8] = src[(b % n)*8 +: 8];
        if (ld) begin
            w = pattern({ea[63:3], 3'b000}) >> (ea[2:0] * 8);
            it.idx = rt;
            if (fpr) begin
                it.fwe = 1;
                it.wb = (n == 4) ? {fpv[63:32], w[31:0]} : w;
            end else begin
                it.gwe = 1;
                case (n)
                    1: it.wb = {{56{w[7]}}, w[7:0]};
                    2: it.wb = {{48{w[15]}}, w[15:0]};
                    4: it.wb = {{32{w[31]}}, w[31:0]};
                    default: it.wb = w;
                endcase
            end
        end
        return it;
    endfunction

    task automatic issue(string tag, logic [5:0] op, logic [4:0] rt, logic [7:0] off, logic [2:0] minor,
                         logic [63:0] rs, logic [63:0] rd, logic [63:0] rtv, logic [63:0] fpv,
                         bit cp1, bit ext);
        @(negedge clk);
        instr_i   = {op, 5'd3, rt, 5'd9, off, minor};
        rs_val_i  = rs; rd_val_i = rd; rt_val_i = rtv; fpr_val_i = fpv;
        cp1_en_i  = cp1; ext_en_i = ext; valid_i = 1'b1;
        q.push_back(predict(tag, op, rt, off, minor, rs, rd, rtv, fpv, cp1, ext));
        @(negedge clk);
        valid_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            @(negedge clk);
            chk(it.tag, "mem_req", mem_req_o, it.req);
            chk(it.tag, "exc_code", exc_code_o, it.exc);
            chk(it.tag, "exc_valid", exc_valid_o, it.exc != 0);
            if (it.req) begin
                chk(it.tag, "mem_we", mem_we_o, it.we);
                chk(it.tag, "mem_addr", mem_addr_o, it.addr);
                chk(it.tag, "mem_be", mem_be_o, it.be);
                if (it.we) chk(it.tag, "mem_wdata", mem_wdata_o, it.wdata);
            end
            @(negedge clk);
            chk(it.tag, "gpr_we", gpr_we_o, it.gwe);
            chk(it.tag, "fpr_we", fpr_we_o, it.fwe);
            if (it.gwe || it.fwe) begin
                chk(it.tag, "wb_idx", wb_idx_o, it.idx);
                chk(it.tag, "wb_data", wb_data_o, it.wb);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [5:0] LD = 6'h36, ST = 6'h3E;
    localparam logic [63:0] V = 64'hFEDC_BA98_7654_3210, F = 64'hA5A5_5A5A_C3C3_3C3C;

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset", "outputs", {mem_req_o, gpr_we_o, fpr_we_o, exc_valid_o}, 0);
        // R1 foreign opcode and disabled extension
        issue("R1", LD, 5, 8'd0, 3'd0, 64'h1000, 64'h1, V, F, 1, 0);
        issue("R1", 6'h23, 5, 8'd0, 3'd0, 64'h1000, 64'h0, V, F, 1, 1);
        // R2 R4 loads of each size at different lanes
        for (int k = 0; k < 8; k++)
            issue("R4", LD, 7, 8'd0, 3'd0, 64'h2000, 64'(k), V, F, 1, 1);
        issue("R4", LD, 8, 8'd2, 3'd1, 64'h2040, 64'h0, V, F, 1, 1);
        issue("R4", LD, 8, 8'd6, 3'd1, 64'h2048, 64'h0, V, F, 1, 1);
        issue("R4", LD, 9, 8'd4, 3'd2, 64'h2100, 64'h8, V, F, 1, 1);
        issue("R4", LD, 9, 8'd0, 3'd2, 64'h2200, 64'h0, V, F, 1, 1);
        issue("R2", LD, 10, 8'hF0, 3'd3, 64'h3000, 64'h20, V, F, 1, 1);
        issue("R2", LD, 11, 8'h7F, 3'd0, 64'h4000, 64'h100, V, F, 1, 1);
        // R5 prefetch, aligned and misaligned
        issue("R5", LD, 0, 8'd0, 3'd3, 64'h5000, 64'h0, V, F, 1, 1);
        issue("R5", LD, 0, 8'd1, 3'd2, 64'h5000, 64'h0, V, F, 1, 1);
        issue("R5", LD, 0, 8'd0, 3'd7, 64'h5000, 64'h0, V, F, 1, 1);
        // R3 reserved codes
        issue("R3", LD, 4, 8'd0, 3'd4, 64'h6000, 64'h0, V, F, 1, 1);
        issue("R3", ST, 4, 8'd0, 3'd5, 64'h6000, 64'h0, V, F, 1, 1);
        issue("R10", LD, 4, 8'd1, 3'd5, 64'h6000, 64'h0, V, F, 0, 1);
        // R8 floating loads
        issue("R8", LD, 12, 8'd4, 3'd6, 64'h7000, 64'h0, V, F, 1, 1);
        issue("R8", LD, 12, 8'd0, 3'd6, 64'h7008, 64'h0, V, F, 1, 1);
        issue("R3", LD, 13, 8'd0, 3'd7, 64'h7010, 64'h0, V, F, 1, 1);
        // R6 coprocessor unusable
        issue("R6", LD, 12, 8'd0, 3'd6, 64'h7000, 64'h0, V, F, 0, 1);
        issue("R6", ST, 12, 8'd0, 3'd7, 64'h7000, 64'h0, V, F, 0, 1);
        issue("R10", ST, 12, 8'd2, 3'd7, 64'h7000, 64'h0, V, F, 0, 1);
        // R7 stores
        for (int k = 0; k < 8; k++)
            issue("R7", ST, 14, 8'd0, 3'd0, 64'h8000, 64'(k), V, F, 1, 1);
        issue("R7", ST, 14, 8'd2, 3'd1, 64'h8000, 64'h4, V, F, 1, 1);
        issue("R7", ST, 14, 8'd4, 3'd2, 64'h8000, 64'h0, V, F, 1, 1);
        issue("R7", ST, 14, 8'd0, 3'd3, 64'h8000, 64'h8, V, F, 1, 1);
        issue("R7", ST, 15, 8'd4, 3'd6, 64'h8000, 64'h0, V, F, 1, 1);
        issue("R7", ST, 15, 8'd0, 3'd7, 64'h8000, 64'h0, V, F, 1, 1);
        issue("R7", ST, 0, 8'd0, 3'd3, 64'h8000, 64'h0, V, F, 1, 1);
        // R9 misalignment
        issue("R9", LD, 6, 8'd1, 3'd1, 64'h9000, 64'h0, V, F, 1, 1);
        issue("R9", LD, 6, 8'd2, 3'd3, 64'h9000, 64'h0, V, F, 1, 1);
        issue("R9", ST, 6, 8'd2, 3'd2, 64'h9000, 64'h0, V, F, 1, 1);
        issue("R9", ST, 6, 8'd4, 3'd7, 64'h9000, 64'h0, V, F, 1, 1);
        wait (q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule